// File: doc/BRIEF.md
# Multi-Source Reset Sequencing Controller

This block gathers every reset request of the device and turns the winning request into a timed reset sequence. A sequence raises the reset-output pin for a length chosen by the current PLL configuration. For every source except the software external request, it also raises the internal reset. The power-on reset is the block's own asynchronous reset. The external reset pin passes through a two-stage synchronizer and then a width filter. A pulse shorter than the filter width does not start a reset; it only sets a glitch flag.

While a sequence runs, the block captures the two boot-mode pins four cycles before the reset output falls. It captures the two PLL-configuration pins on the edge where the reset output falls. If the configuration-enable pin is low at a capture edge, the block stores the default value instead. A status word records which source started the last reset. A one-cycle start pulse tells the boot-assist logic to run after each internal reset.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low, `int_rst_o` and `rst_out_o` are 1 and `status_o` is 0x001 (power-on only, glitch flag cleared). After `rst_ni` rises, the outputs stay high for the hold length of the default PLL configuration.
- R2: At the start of each sequence, `status_o[8:0]` becomes one-hot with the starting source. Bit 0 is power-on, 1 the external pin, 2 loss-of-lock, 3 loss-of-clock, 4 watchdog/debug, 5 JTAG, 6 checkstop, 7 software system and 8 software external.
- R3: When several sources request in the same cycle, the one with the lowest status bit index is recorded and sets the reset type.
- R4: For every source except software external, `int_rst_o` is high in exactly the cycles where `rst_out_o` is high.
- R5: A software external request pulses `rst_out_o` for the hold length, keeps `int_rst_o` at 0 and gives no boot-assist pulse.
- R6: `rst_out_o` stays high for HOLD_C0, HOLD_C1, HOLD_C2 or HOLD_C3 cycles (defaults 8, 12, 16, 24). The value of `pll_cfg_o` at the start of the sequence (0 to 3) selects which one.
- R7: On the clock edge four cycles before `rst_out_o` falls, `boot_mode_o` takes `boot_pins_i` if `cfg_en_i` is 1.
- R8: On the clock edge where `rst_out_o` falls, `pll_cfg_o` takes `pll_pins_i` if `cfg_en_i` is 1. Otherwise it does not change.
- R9: If `cfg_en_i` is 0 at those capture edges, `boot_mode_o` becomes 2'b00 (internal flash) and `pll_cfg_o` becomes 2'b01 (PLL on, crystal reference). Both also reset to these values.
- R10: After an internal reset, `bam_start_o` is high for one cycle: the first cycle in which `rst_out_o` is low.
- R11: `ext_rst_ni` low for at least FILT_W (default 3) consecutive synchronized cycles starts a reset recorded as the external pin. A shorter low pulse starts no reset.
- R12: A low pulse on `ext_rst_ni` shorter than FILT_W sets `status_o[9]`. This flag survives later non-power-on resets and is cleared only by power-on reset.
- R13: Requests that arrive while a sequence is running are ignored. They neither lengthen the sequence nor change the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous to clk_i |
| lol_i | input | 1 | Loss-of-lock request |
| loc_i | input | 1 | Loss-of-clock request |
| wdog_i | input | 1 | Watchdog or debug request |
| jtag_i | input | 1 | JTAG reset request |
| chkstop_i | input | 1 | Checkstop request |
| sw_sys_i | input | 1 | Software system reset write pulse |
| sw_ext_i | input | 1 | Software external reset write pulse |
| cfg_en_i | input | 1 | Use configuration pins instead of defaults |
| boot_pins_i | input | 2 | Boot-mode pins |
| pll_pins_i | input | 2 | PLL-configuration pins |
| int_rst_o | output | 1 | Internal device reset |
| rst_out_o | output | 1 | Reset-output pin, active high |
| bam_start_o | output | 1 | Boot-assist start pulse |
| status_o | output | 10 | Last reset cause [8:0], glitch flag [9] |
| boot_mode_o | output | 2 | Latched boot mode |
| pll_cfg_o | output | 2 | Latched PLL configuration |

## Verification
The checker watches several rules on every cycle: internal reset only while the reset output is high, a single recorded cause, a sticky glitch flag, and a boot-assist pulse only right after an internal reset ends. It also checks that the boot and PLL fields change only inside their capture windows and that each sequence lasts at least five cycles. Only the directed scenarios can show the rest. These are the exact hold length for each PLL setting, the exact capture edges (the bench changes the pins one cycle before and one cycle after each edge), the priority order, the filter threshold, and requests being ignored during a sequence.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int N_SRC  = 9;
  localparam int STAT_W = N_SRC + 1;
  localparam int SRC_POR = 0;
  localparam int SRC_EXT = 1;
  localparam int SRC_LOL = 2;
  localparam int SRC_LOC = 3;
  localparam int SRC_WDG = 4;
  localparam int SRC_JTG = 5;
  localparam int SRC_CHK = 6;
  localparam int SRC_SWS = 7;
  localparam int SRC_SWX = 8;
  localparam int GLITCH_BIT = 9;
  localparam int BOOT_EARLY = 4;
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int FILT_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic req_o,
  output logic glitch_o
);
  localparam int CW = $clog2(FILT_W + 1);

  logic s1_q, s2_q;
  logic [CW-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      low_q <= '0;
    end else begin
      s1_q <= pin_ni;
      s2_q <= s1_q;
      if (s2_q) low_q <= '0;
      else if (low_q != CW'(FILT_W)) low_q <= low_q + 1'b1;
    end
  end

  // request once per qualified low period
  assign req_o    = !s2_q && (low_q == CW'(FILT_W - 1));
  assign glitch_o = s2_q && (low_q != '0) && (low_q < CW'(FILT_W));
endmodule

// File: rtl/rst_src_arb.sv
module rst_src_arb #(
  parameter int N = 9
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  always_comb begin
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) grant_o = N'(1) << i;
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm #(
  parameter int HOLD_C0 = 8,
  parameter int HOLD_C1 = 12,
  parameter int HOLD_C2 = 16,
  parameter int HOLD_C3 = 24,
  parameter logic [1:0] BOOT_DFLT = 2'b00,
  parameter logic [1:0] PLL_DFLT  = 2'b01
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       int_i,
  input  logic       cfg_en_i,
  input  logic [1:0] boot_pins_i,
  input  logic [1:0] pll_pins_i,
  output logic       rst_out_o,
  output logic       int_rst_o,
  output logic       bam_start_o,
  output logic [1:0] boot_mode_o,
  output logic [1:0] pll_cfg_o
);
  import rst_seq_pkg::*;

  localparam int HM01  = (HOLD_C0 > HOLD_C1) ? HOLD_C0 : HOLD_C1;
  localparam int HM23  = (HOLD_C2 > HOLD_C3) ? HOLD_C2 : HOLD_C3;
  localparam int HMAX  = (HM01 > HM23) ? HM01 : HM23;
  localparam int CNT_W = $clog2(HMAX);

  function automatic logic [CNT_W-1:0] hold_m1(input logic [1:0] c);
    case (c)
      2'd0:    return CNT_W'(HOLD_C0 - 1);
      2'd1:    return CNT_W'(HOLD_C1 - 1);
      2'd2:    return CNT_W'(HOLD_C2 - 1);
      default: return CNT_W'(HOLD_C3 - 1);
    endcase
  endfunction

  logic             busy_q, int_q, bam_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       boot_q, pll_q;
  logic [1:0]       cap_boot, cap_pll;

  assign cap_boot = cfg_en_i ? boot_pins_i : BOOT_DFLT;
  assign cap_pll  = cfg_en_i ? pll_pins_i  : PLL_DFLT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;
      int_q  <= 1'b1;
      bam_q  <= 1'b0;
      cnt_q  <= hold_m1(PLL_DFLT);
      boot_q <= BOOT_DFLT;
      pll_q  <= PLL_DFLT;
    end else begin
      bam_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          int_q  <= int_i;
          cnt_q  <= hold_m1(pll_q);
        end
      end else begin
        if (cnt_q == CNT_W'(BOOT_EARLY)) boot_q <= cap_boot;
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          pll_q  <= cap_pll;
          bam_q  <= int_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign rst_out_o   = busy_q;
  assign int_rst_o   = busy_q & int_q;
  assign bam_start_o = bam_q;
  assign boot_mode_o = boot_q;
  assign pll_cfg_o   = pll_q;
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int HOLD_C0 = 8,
  parameter int HOLD_C1 = 12,
  parameter int HOLD_C2 = 16,
  parameter int HOLD_C3 = 24,
  parameter int FILT_W  = 3,
  parameter logic [1:0] BOOT_DFLT = 2'b00,
  parameter logic [1:0] PLL_DFLT  = 2'b01
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_rst_ni,
  input  logic       lol_i,
  input  logic       loc_i,
  input  logic       wdog_i,
  input  logic       jtag_i,
  input  logic       chkstop_i,
  input  logic       sw_sys_i,
  input  logic       sw_ext_i,
  input  logic       cfg_en_i,
  input  logic [1:0] boot_pins_i,
  input  logic [1:0] pll_pins_i,
  output logic       int_rst_o,
  output logic       rst_out_o,
  output logic       bam_start_o,
  output logic [9:0] status_o,
  output logic [1:0] boot_mode_o,
  output logic [1:0] pll_cfg_o
);
  import rst_seq_pkg::*;

  logic             ext_req, glitch_p, any_req, start;
  logic [N_SRC-1:0] req, grant;
  logic [STAT_W-1:0] stat_q;

  rst_pin_filter #(.FILT_W(FILT_W)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_ni(ext_rst_ni),
    .req_o(ext_req), .glitch_o(glitch_p)
  );

  // power-on slot is driven by the asynchronous reset itself
  assign req = {sw_ext_i, sw_sys_i, chkstop_i, jtag_i, wdog_i,
                loc_i, lol_i, ext_req, 1'b0};

  rst_src_arb #(.N(N_SRC)) u_arb (
    .req_i(req), .grant_o(grant), .any_o(any_req)
  );

  assign start = any_req & ~rst_out_o;

  rst_seq_fsm #(
    .HOLD_C0(HOLD_C0), .HOLD_C1(HOLD_C1), .HOLD_C2(HOLD_C2), .HOLD_C3(HOLD_C3),
    .BOOT_DFLT(BOOT_DFLT), .PLL_DFLT(PLL_DFLT)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .int_i(~grant[SRC_SWX]),
    .cfg_en_i(cfg_en_i), .boot_pins_i(boot_pins_i), .pll_pins_i(pll_pins_i),
    .rst_out_o(rst_out_o), .int_rst_o(int_rst_o), .bam_start_o(bam_start_o),
    .boot_mode_o(boot_mode_o), .pll_cfg_o(pll_cfg_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= STAT_W'(1) << SRC_POR;
    end else if (start) begin
      stat_q <= {stat_q[GLITCH_BIT] | glitch_p, grant};
    end else begin
      stat_q[GLITCH_BIT] <= stat_q[GLITCH_BIT] | glitch_p;
    end
  end

  assign status_o = stat_q;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       int_rst_o,
  input logic       rst_out_o,
  input logic       bam_start_o,
  input logic [9:0] status_o,
  input logic [1:0] boot_mode_o,
  input logic [1:0] pll_cfg_o
);
  logic [7:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_q <= '0;
    else if (!rst_out_o) hi_q <= '0;
    else if (hi_q != 8'hff) hi_q <= hi_q + 1'b1;
  end

  // R4
  int_in_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o |-> rst_out_o);

  // R2
  one_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_o[8:0]) == 1);

  // R12
  glitch_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(status_o[9]) |-> status_o[9]);

  // R10
  bam_after_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bam_start_o |-> (!rst_out_o && $past(int_rst_o)));

  // R7
  boot_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_out_o || !$past(rst_out_o)) |-> $stable(boot_mode_o));

  // R8
  pll_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_out_o || !$past(rst_out_o)) |-> $stable(pll_cfg_o));

  // R6
  min_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_out_o) |-> (hi_q >= 8'd5));
endmodule

bind rst_seq_ctrl rst_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .int_rst_o(int_rst_o), .rst_out_o(rst_out_o),
  .bam_start_o(bam_start_o), .status_o(status_o), .boot_mode_o(boot_mode_o),
  .pll_cfg_o(pll_cfg_o)
);

// File: tb/tb_rst_seq_ctrl.sv
module tb_rst_seq_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0, ext_rst_ni = 1'b1;
  logic lol = 0, loc = 0, wdog = 0, jtag = 0, chk = 0, sws = 0, swx = 0;
  logic cfg_en = 0;
  logic [1:0] boot_pins = 2'b00, pll_pins = 2'b00;
  logic int_rst, rst_out, bam;
  logic [9:0] status;
  logic [1:0] boot_mode, pll_cfg;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rst_seq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni),
    .lol_i(lol), .loc_i(loc), .wdog_i(wdog), .jtag_i(jtag), .chkstop_i(chk),
    .sw_sys_i(sws), .sw_ext_i(swx), .cfg_en_i(cfg_en),
    .boot_pins_i(boot_pins), .pll_pins_i(pll_pins),
    .int_rst_o(int_rst), .rst_out_o(rst_out), .bam_start_o(bam),
    .status_o(status), .boot_mode_o(boot_mode), .pll_cfg_o(pll_cfg)
  );

  task automatic chk_eq(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", r, act, exp);
    end
  endtask

  // drives a source vector for one cycle; bits follow status positions
  task automatic pulse(input logic [8:0] v);
    @(negedge clk);
    lol = v[2]; loc = v[3]; wdog = v[4]; jtag = v[5];
    chk = v[6]; sws = v[7]; swx = v[8];
    @(negedge clk);
    {lol, loc, wdog, jtag, chk, sws, swx} = '0;
  endtask

  // call at a negedge; counts reset-output cycles
  task automatic measure(input string r, input int n, input logic exp_int,
                         input logic exp_bam, input bit do_cfg, input int inj_m);
    int len = 0;
    int bad_int = 0;
    for (int w = 0; w < 20 && !rst_out; w++) @(negedge clk);
    while (rst_out && len < 64) begin
      if (do_cfg && len == n - 5) boot_pins = 2'b10;
      if (do_cfg && len == n - 4) boot_pins = 2'b01;
      if (do_cfg && len == n - 1) pll_pins  = 2'b11;
      if (len == inj_m) wdog = 1'b1;
      if (len == inj_m + 1) wdog = 1'b0;
      if (int_rst != exp_int) bad_int++;
      len++;
      @(negedge clk);
    end
    wdog = 1'b0;
    chk_eq({r, " length"}, len, n);
    chk_eq({r, " R4 int_rst tracks"}, bad_int, 0);
    chk_eq({r, " R10 bam"}, bam, exp_bam);
    @(negedge clk);
    chk_eq({r, " R10 bam one cycle"}, bam, 0);
  endtask

  task automatic t_reset_state();
    rst_ni = 0;
    #12;
    chk_eq("R1 int in reset", int_rst, 1);
    chk_eq("R1 out in reset", rst_out, 1);
    chk_eq("R1 status", status, 10'h001);
    chk_eq("R9 boot reset", boot_mode, 0);
    chk_eq("R9 pll reset", pll_cfg, 1);
  endtask

  task automatic t_por();
    @(negedge clk);
    rst_ni = 1;
    measure("R1 por", 12, 1, 1, 0, -10);
    chk_eq("R1 por status", status, 10'h001);
    chk_eq("R9 boot dflt", boot_mode, 0);
    chk_eq("R9 pll dflt", pll_cfg, 1);
  endtask

  task automatic t_sources();
    for (int i = 2; i <= 7; i++) begin
      pulse(9'(1) << i);
      measure("R2 src", 12, 1, 1, 0, -10);
      chk_eq("R2 status cause", status, 1 << i);
    end
  endtask

  task automatic t_sw_ext();
    pulse(9'h100);
    measure("R5 swext", 12, 0, 0, 0, -10);
    chk_eq("R5 status", status, 10'h100);
  endtask

  task automatic t_priority();
    pulse(9'h084);
    measure("R3 lol+sws", 12, 1, 1, 0, -10);
    chk_eq("R3 cause lol", status, 10'h004);
    pulse(9'h110);
    measure("R3 wdog+swx", 12, 1, 1, 0, -10);
    chk_eq("R3 cause wdog", status, 10'h010);
  endtask

  task automatic t_cfg();
    cfg_en = 1; boot_pins = 2'b11; pll_pins = 2'b00;
    pulse(9'h080);
    measure("R7 R8 cfg", 12, 1, 1, 1, -10);
    chk_eq("R7 boot captured early", boot_mode, 2'b10);
    chk_eq("R8 pll at release", pll_cfg, 2'b11);
    boot_pins = 2'b11; pll_pins = 2'b10;
    pulse(9'h020);
    measure("R6 cfg3", 24, 1, 1, 0, -10);
    chk_eq("R7 boot", boot_mode, 2'b11);
    chk_eq("R8 pll", pll_cfg, 2'b10);
    cfg_en = 0; boot_pins = 2'b01; pll_pins = 2'b11;
    pulse(9'h040);
    measure("R6 cfg2", 16, 1, 1, 0, -10);
    chk_eq("R9 boot dflt", boot_mode, 2'b00);
    chk_eq("R9 pll dflt", pll_cfg, 2'b01);
    boot_pins = 2'b00; pll_pins = 2'b00;
  endtask

  task automatic t_busy_ignore();
    pulse(9'h080);
    measure("R13 busy", 12, 1, 1, 0, 3);
    chk_eq("R13 status kept", status, 10'h080);
    repeat (4) @(negedge clk);
    chk_eq("R13 no retrigger", rst_out, 0);
  endtask

  task automatic t_ext_pin();
    @(negedge clk);
    ext_rst_ni = 0;
    fork
      begin repeat (5) @(negedge clk); ext_rst_ni = 1; end
    join_none
    measure("R11 ext", 12, 1, 1, 0, -10);
    chk_eq("R11 ext cause", status, 10'h002);
  endtask

  task automatic t_glitch();
    int hi = 0;
    @(negedge clk);
    ext_rst_ni = 0;
    repeat (2) @(negedge clk);
    ext_rst_ni = 1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (rst_out) hi++;
    end
    chk_eq("R11 short pulse no reset", hi, 0);
    chk_eq("R12 glitch flag", status, 10'h202);
    pulse(9'h008);
    measure("R12 loc", 12, 1, 1, 0, -10);
    chk_eq("R12 flag kept", status, 10'h208);
  endtask

  task automatic t_por_again();
    @(negedge clk);
    rst_ni = 0;
    @(negedge clk);
    chk_eq("R1 R12 por clears", status, 10'h001);
    rst_ni = 1;
    measure("R1 por2", 12, 1, 1, 0, -10);
  endtask

  initial begin
    t_reset_state();
    t_por();
    t_sources();
    t_sw_ext();
    t_priority();
    t_cfg();
    t_busy_ignore();
    t_ext_pin();
    t_glitch();
    t_por_again();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule